// File: doc/BRIEF.md
# SPI FIFO Event and Mask Unit

This unit sits between a register bus and the shift engine of a serial peripheral interface controller. It holds a transmit FIFO and a receive FIFO of 32 bytes each. It publishes a 32-bit event word that packs the receive fill level, the free transmit space and a set of status flags. A mask word with the same bit layout selects which of those flags drive a single interrupt line.

Software fills the transmit FIFO and drains the receive FIFO one byte at a time through two data addresses. The shift engine is represented here by three strobes: a transmit pop, a receive push carrying a byte, and a frame-done pulse. Some flags follow the FIFO state directly. The done, threshold and full flags are sticky and are cleared by writing ones to the event word. A mode word holds the two programmable thresholds.

The register addresses are word indices: 0 is mode, 1 is event, 2 is mask, 3 is transmit data (write only) and 4 is receive data. A read of address 4 returns the oldest receive byte in bits 7:0 and removes it from the FIFO.

Top module: `spi_fifo_evt_unit`

## Requirements
- R1: Once reset ends, the event word reads 0x00208900: receive count 0, transmit space 32, transmit-empty (bit 15), transmit-threshold (bit 11) and transmit-not-full (bit 8) set. The mode word reads 0x0000040F, the mask reads 0 and the interrupt is low.
- R2: Bits 29:24 of the event word give the receive byte count. Bits 21:16 give the free transmit space. Both are 6-bit fields, and all other bits outside 15:8 read zero.
- R3: Bit 15 (transmit FIFO empty), bit 9 (receive FIFO not empty) and bit 8 (transmit FIFO not full) follow the live FIFO levels and cannot be cleared by a write.
- R4: Bit 13 becomes set and stays set once the receive count is strictly greater than the receive threshold. A count equal to the threshold does not set it.
- R5: Bit 12 becomes set and stays set once the receive FIFO holds 32 bytes.
- R6: Bit 11 becomes set and stays set once the free transmit space is strictly greater than the transmit threshold.
- R7: A pulse on the done strobe sets bit 14, and the bit stays set.
- R8: Writing the event address clears each sticky flag (bits 14..11) whose written bit is one. Writing zeros changes nothing. A flag whose set condition still holds in the clearing cycle stays set.
- R9: Only bits 15, 14, 13, 12, 11, 9 and 8 of the mask are writable, and all other mask bits read zero. The interrupt is high exactly when some event flag is set and its mask bit is one.
- R10: Each FIFO delivers bytes in arrival order. A push into a full FIFO is dropped, and a pop from an empty FIFO leaves its count unchanged.
- R11: The mode word holds the transmit threshold in bits 13:8 and the receive threshold in bits 5:0. Both are writable and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 4) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| eng_tx_pop | input | 1 | Shift engine takes the head transmit byte |
| eng_tx_data | output | 8 | Head transmit byte |
| eng_rx_push | input | 1 | Shift engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_done | input | 1 | Frame-done pulse |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench probes the strict threshold comparisons. It holds the receive count exactly at the threshold and then one byte above it, so a design that compares with greater-or-equal raises the flag too early. It clears a sticky flag while its condition still holds, and also after the condition has gone. A design that gives the clear priority would drop the flag in the first case, and one that ignores the clear would keep it in the second. It pushes a 33rd byte into each FIFO and pops empty FIFOs, so a design that wraps the counters would report counts of 0 or 33 and reorder the data. It writes all ones to the mask, so a design that keeps unimplemented bits would read them back. It also drives the interrupt from a live level flag as well as from a sticky one.

// File: rtl/spi_fevt_pkg.sv
package spi_fevt_pkg;

  localparam int FIFO_DEPTH_DEF = 32;

  // event / mask flag positions
  localparam int F_TXE  = 15;
  localparam int F_DONE = 14;
  localparam int F_RXT  = 13;
  localparam int F_RXF  = 12;
  localparam int F_TXT  = 11;
  localparam int F_RNE  = 9;
  localparam int F_TNF  = 8;

  localparam logic [15:0] FLAG_BITS = 16'((1 << F_TXE) | (1 << F_DONE) | (1 << F_RXT) |
                                          (1 << F_RXF) | (1 << F_TXT) | (1 << F_RNE) |
                                          (1 << F_TNF));

  // sticky flags, index order shared by set and clear vectors
  localparam int N_STICKY = 4;
  localparam int STICKY_POS [N_STICKY] = '{F_TXT, F_RXF, F_RXT, F_DONE};

  // field positions inside the packed words
  localparam int RXCNT_LSB  = 24;
  localparam int TXFREE_LSB = 16;
  localparam int TXTHR_LSB  = 8;
  localparam int RXTHR_LSB  = 0;

  typedef enum logic [2:0] {
    ADR_MODE = 3'd0,
    ADR_EVT  = 3'd1,
    ADR_MASK = 3'd2,
    ADR_TXD  = 3'd3,
    ADR_RXD  = 3'd4
  } reg_adr_e;

endpackage

// File: rtl/spi_fevt_fifo.sv
module spi_fevt_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [WIDTH-1:0]         push_data,
  input  logic                     pop,
  output logic [WIDTH-1:0]         head,
  output logic [$clog2(DEPTH):0]   count
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign push_ok = push && (cnt_q != FULL_CNT);
  assign pop_ok  = pop && (cnt_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr_q] <= push_data;
    end
  end

  assign head  = (cnt_q == '0) ? '0 : mem[rd_ptr_q];
  assign count = cnt_q;

  AST_FIFO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R10
  AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL_CNT && push && !pop) |=> (cnt_q == FULL_CNT)); // R10
  AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop && !push) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/spi_fevt_flags.sv
module spi_fevt_flags
  import spi_fevt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH):0]   rx_cnt,
  input  logic [$clog2(DEPTH):0]   tx_free,
  input  logic [$clog2(DEPTH):0]   rx_thr,
  input  logic [$clog2(DEPTH):0]   tx_thr,
  input  logic                     done_stb,
  input  logic                     clr_en,
  input  logic [N_STICKY-1:0]      clr_vec,
  output logic [15:0]              flags
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [N_STICKY-1:0] set_c;
  logic [N_STICKY-1:0] sticky_q, sticky_d;

  // index order follows STICKY_POS: txt, rxf, rxt, done
  assign set_c = {done_stb, (rx_cnt > rx_thr), (rx_cnt == FULL_CNT), (tx_free > tx_thr)};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    logic clr_g;
    assign clr_g       = clr_en & clr_vec[g];
    assign sticky_d[g] = (sticky_q[g] & ~clr_g) | set_c[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else begin
      sticky_q <= sticky_d;
    end
  end

  always_comb begin
    flags        = '0;
    flags[F_TXE] = (tx_free == FULL_CNT);
    flags[F_RNE] = (rx_cnt != '0);
    flags[F_TNF] = (tx_free != '0);
    for (int i = 0; i < N_STICKY; i++) begin
      flags[STICKY_POS[i]] = sticky_q[i];
    end
  end

  AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |=> flags[F_DONE]); // R7
  AST_RXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt > rx_thr) |=> flags[F_RXT]); // R4
  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == FULL_CNT) |=> flags[F_RXF]); // R5
  AST_TXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free > tx_thr) |=> flags[F_TXT]); // R6
  AST_RXT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_vec[2] && !(rx_cnt > rx_thr)) |=> !flags[F_RXT]); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_DONE] && !clr_en) |=> flags[F_DONE]); // R8

endmodule

// File: rtl/spi_fifo_evt_unit.sv
module spi_fifo_evt_unit
  import spi_fevt_pkg::*;
#(
  parameter int DEPTH     = FIFO_DEPTH_DEF,
  parameter int TXTHR_RST = 4,
  parameter int RXTHR_RST = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_done,
  output logic        irq
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // decode
  logic wr_mode, wr_evt, wr_mask, wr_txd, rd_rxd;
  assign wr_mode = reg_wr && (reg_addr == ADR_MODE);
  assign wr_evt  = reg_wr && (reg_addr == ADR_EVT);
  assign wr_mask = reg_wr && (reg_addr == ADR_MASK);
  assign wr_txd  = reg_wr && (reg_addr == ADR_TXD);
  assign rd_rxd  = reg_rd && (reg_addr == ADR_RXD);

  // mode and mask registers
  logic [CW-1:0] tx_thr_q, tx_thr_d;
  logic [CW-1:0] rx_thr_q, rx_thr_d;
  logic [15:0]   mask_q, mask_d;

  always_comb begin
    tx_thr_d = tx_thr_q;
    rx_thr_d = rx_thr_q;
    mask_d   = mask_q;
    if (wr_mode) begin
      tx_thr_d = reg_wdata[TXTHR_LSB +: CW];
      rx_thr_d = reg_wdata[RXTHR_LSB +: CW];
    end
    if (wr_mask) begin
      mask_d = reg_wdata & FLAG_BITS;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tx_thr_q <= CW'(TXTHR_RST);
      rx_thr_q <= CW'(RXTHR_RST);
      mask_q   <= '0;
    end else begin
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
      mask_q   <= mask_d;
    end
  end

  // FIFOs
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic [7:0]    rx_head;

  spi_fevt_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (wr_txd),
    .push_data (reg_wdata[7:0]),
    .pop       (eng_tx_pop),
    .head      (eng_tx_data),
    .count     (tx_cnt)
  );

  spi_fevt_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (eng_rx_push),
    .push_data (eng_rx_data),
    .pop       (rd_rxd),
    .head      (rx_head),
    .count     (rx_cnt)
  );

  assign tx_free = FULL_CNT - tx_cnt;

  // flags
  logic [N_STICKY-1:0] clr_vec;
  logic [15:0]         flags;

  always_comb begin
    for (int i = 0; i < N_STICKY; i++) begin
      clr_vec[i] = reg_wdata[STICKY_POS[i]];
    end
  end

  spi_fevt_flags #(.DEPTH(DEPTH)) i_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_cnt   (rx_cnt),
    .tx_free  (tx_free),
    .rx_thr   (rx_thr_q),
    .tx_thr   (tx_thr_q),
    .done_stb (eng_done),
    .clr_en   (wr_evt),
    .clr_vec  (clr_vec),
    .flags    (flags)
  );

  assign irq = |(flags & mask_q);

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_MODE: begin
        reg_rdata[TXTHR_LSB +: CW] = tx_thr_q;
        reg_rdata[RXTHR_LSB +: CW] = rx_thr_q;
      end
      ADR_EVT: begin
        reg_rdata[RXCNT_LSB +: CW]  = rx_cnt;
        reg_rdata[TXFREE_LSB +: CW] = tx_free;
        reg_rdata[15:0]             = flags;
      end
      ADR_MASK: reg_rdata[15:0] = mask_q;
      ADR_RXD:  reg_rdata[7:0]  = rx_head;
      default:  reg_rdata = '0;
    endcase
  end

  AST_IRQ_NO_MASK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_q == '0) |-> !irq); // R9
  AST_MASK_RSVD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_q & ~FLAG_BITS) == '0); // R9
  AST_TXT_FROM_MODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_mode && (reg_wdata[TXTHR_LSB +: CW] < tx_free)) |=> ##1 flags[F_TXT]); // R6

endmodule

// File: tb/test_spi_fifo_evt_unit.sv
module test_spi_fifo_evt_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        eng_tx_pop, eng_rx_push, eng_done;
  logic [7:0]  eng_tx_data, eng_rx_data;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_evt_unit i_spi_fifo_evt_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = (a == 3'd4);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rx_push(logic [7:0] b);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_pop(output logic [7:0] b);
    @(negedge clk);
    eng_tx_pop = 1'b1;
    #1 b = eng_tx_data;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    settle();
    rd(3'd1, d); check("R1 event after reset", d, 32'h0020_8900);
    rd(3'd0, d); check("R1 mode after reset", d, 32'h0000_040F);
    rd(3'd2, d); check("R1 mask after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    logic [7:0]  b;
    wr(3'd3, 16'h00A1); wr(3'd3, 16'h00B2); wr(3'd3, 16'h00C3);
    settle();
    rd(3'd1, d);
    check("R2 tx free after 3 pushes", {26'b0, d[21:16]}, 32'd29);
    check("R3 tx empty low", {31'b0, d[15]}, 32'd0);
    check("R3 tx not full high", {31'b0, d[8]}, 32'd1);
    tx_pop(b); check("R10 tx order 0", {24'b0, b}, 32'hA1);
    tx_pop(b); check("R10 tx order 1", {24'b0, b}, 32'hB2);
    tx_pop(b); check("R10 tx order 2", {24'b0, b}, 32'hC3);
    tx_pop(b);
    settle();
    rd(3'd1, d);
    check("R10 tx pop on empty", {26'b0, d[21:16]}, 32'd32);
    check("R3 tx empty high again", {31'b0, d[15]}, 32'd1);
    rx_push(8'h5A); rx_push(8'h6B);
    settle();
    rd(3'd1, d);
    check("R2 rx count 2", {26'b0, d[29:24]}, 32'd2);
    check("R3 rx not empty", {31'b0, d[9]}, 32'd1);
    rd(3'd4, d); check("R10 rx order 0", d, 32'h5A);
    rd(3'd4, d); check("R10 rx order 1", d, 32'h6B);
    rd(3'd4, d);
    settle();
    rd(3'd1, d);
    check("R10 rx pop on empty", {26'b0, d[29:24]}, 32'd0);
    check("R3 rx not empty clear", {31'b0, d[9]}, 32'd0);
  endtask

  task automatic t_rx_thresh();
    logic [31:0] d;
    wr(3'd0, 16'h0402);
    rd(3'd0, d); check("R11 mode readback", d, 32'h0000_0402);
    rx_push(8'h01); rx_push(8'h02);
    settle();
    rd(3'd1, d); check("R4 rx count equal threshold no flag", {31'b0, d[13]}, 32'd0);
    rx_push(8'h03);
    settle();
    rd(3'd1, d); check("R4 rx count above threshold flag", {31'b0, d[13]}, 32'd1);
    for (int i = 0; i < 3; i++) rd(3'd4, d);
    settle();
    rd(3'd1, d); check("R4 rx threshold sticky after drain", {31'b0, d[13]}, 32'd1);
    wr(3'd1, 16'h0000);
    settle();
    rd(3'd1, d); check("R8 zero write keeps flag", {31'b0, d[13]}, 32'd1);
    wr(3'd1, 16'h2000);
    settle();
    rd(3'd1, d); check("R8 one write clears flag", {31'b0, d[13]}, 32'd0);
    wr(3'd0, 16'h040F);
  endtask

  task automatic t_rx_full();
    logic [31:0] d;
    for (int i = 0; i < 33; i++) rx_push(8'(i));
    settle();
    rd(3'd1, d);
    check("R10 rx count saturates", {26'b0, d[29:24]}, 32'd32);
    check("R5 rx full flag", {31'b0, d[12]}, 32'd1);
    for (int i = 0; i < 32; i++) begin
      rd(3'd4, d);
      if (i == 0)  check("R10 rx first byte", d, 32'd0);
      if (i == 31) check("R10 rx last byte, 33rd dropped", d, 32'd31);
    end
    settle();
    rd(3'd1, d); check("R5 rx full sticky", {31'b0, d[12]}, 32'd1);
    wr(3'd1, 16'h3000);
    settle();
    rd(3'd1, d); check("R8 clear full and threshold", {30'b0, d[13:12]}, 32'd0);
  endtask

  task automatic t_tx_thresh();
    logic [31:0] d;
    logic [7:0]  b;
    wr(3'd0, 16'h1E0F);
    wr(3'd1, 16'h0800);
    settle();
    rd(3'd1, d); check("R8 clear loses to live condition", {31'b0, d[11]}, 32'd1);
    wr(3'd3, 16'h0011); wr(3'd3, 16'h0022);
    wr(3'd1, 16'h0800);
    settle();
    rd(3'd1, d); check("R6 free equal threshold, cleared", {31'b0, d[11]}, 32'd0);
    for (int i = 0; i < 31; i++) wr(3'd3, 16'(i));
    settle();
    rd(3'd1, d);
    check("R10 tx push when full dropped", {26'b0, d[21:16]}, 32'd0);
    check("R3 tx not full low", {31'b0, d[8]}, 32'd0);
    for (int i = 0; i < 32; i++) begin
      tx_pop(b);
      if (i == 1) check("R10 tx order after fill", {24'b0, b}, 32'h22);
    end
    settle();
    rd(3'd1, d); check("R6 free above threshold sets", {31'b0, d[11]}, 32'd1);
    wr(3'd0, 16'h040F);
  endtask

  task automatic t_done_irq();
    logic [31:0] d;
    wr(3'd2, 16'hFFFF);
    rd(3'd2, d); check("R9 mask writable bits only", d, 32'h0000_FB00);
    wr(3'd2, 16'h4000);
    settle();
    check("R9 irq low before done", {31'b0, irq}, 32'd0);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    settle();
    rd(3'd1, d); check("R7 done flag set", {31'b0, d[14]}, 32'd1);
    check("R9 irq from done", {31'b0, irq}, 32'd1);
    wr(3'd1, 16'h4000);
    settle();
    check("R8 irq low after done clear", {31'b0, irq}, 32'd0);
    wr(3'd2, 16'h8000);
    settle();
    check("R9 irq from live tx empty", {31'b0, irq}, 32'd1);
    wr(3'd1, 16'h8000);
    settle();
    check("R3 write cannot clear level flag", {31'b0, irq}, 32'd1);
    wr(3'd2, 16'h0000);
    settle();
    check("R9 irq low with mask zero", {31'b0, irq}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    eng_tx_pop = 1'b0; eng_rx_push = 1'b0; eng_rx_data = '0; eng_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_order();
    t_rx_thresh();
    t_rx_full();
    t_tx_thresh();
    t_done_irq();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule